// File: doc/BRIEF.md
# LCD Host Command and Display-Data Front End

This block sits between a serial slave receiver, which has already found the start and stop conditions and assembled whole bytes, and the rest of a dot-matrix LCD controller. The block only receives writes. For each transaction it checks the address byte. It then reads a control byte whose flags say two things: whether the bytes that follow are instructions or display data, and whether one byte or a whole run of bytes follows before the next control byte.

Instruction bytes update the configuration state. This state holds the power-down flag, the instruction page, the contrast code, the temperature-coefficient code and the voltage-multiplier code, and it also loads the RAM address pointer. Data bytes come out as single-cycle write strobes into a display RAM of 6 banks by 128 columns. A column/bank pointer advances after every write. The bank after the last ordinary bank is kept for icons, and the pointer never leaves it on its own. The power-down flag is also brought out as a drive-off request for the waveform path.

Top module: `lcd_host_frontend`

## Requirements
- R1: After a synchronous reset, the outputs are power_down = 1, drive_off = 1, page_sel = 0, vop_code = 0, tc_code = 0, mult_code = 0 and ram_we = 0, and the write pointer is column 0, bank 0.
- R2: The first byte after bus_start is the address byte. Only the value {SLAVE_ADDR, 1'b0} (0x78 by default) is acknowledged. A read bit (bit 0 = 1) or any other address gives no acknowledge, and every later byte up to the next bus_start is ignored: no acknowledge, no RAM write and no change to configuration or pointer.
- R3: Each accepted byte raises byte_ack for one cycle, in the cycle after its byte_valid. The byte after the address is a control byte: bit 7 is the continuation flag and bit 6 selects the destination (0 = instruction, 1 = display data).
- R4: With the continuation flag at 1, exactly one byte of the selected type follows, and the byte after it is read as a new control byte.
- R5: With the continuation flag at 0, every later byte up to bus_stop or bus_start is of the selected type, whatever its value.
- R6: A data byte produces ram_we = 1 one cycle after its byte_valid, with ram_bank and ram_col equal to the pointer before the write and ram_wdata equal to the byte. The column then advances by one.
- R7: When a write is made at the last column in a data bank other than the last data bank, the pointer goes to column 0 of the next bank. After a write at the last column of the last data bank (bank 4 by default), the pointer goes to column 0, bank 0.
- R8: When a write is made at the last column of the icon bank (the highest bank, 5), the column returns to 0 and the bank stays at the icon bank.
- R9: The instruction 001x_xPHH (bits 7:5 = 001) runs on every page. It sets power_down to P (bit 2) and page_sel to HH (bits 1:0). drive_off follows power_down.
- R10: On page 0, 1xxx_xxxx loads the column pointer with bits 6:0. 0100_0yyy loads the bank pointer with yyy, and it has no effect when yyy is not below the bank count.
- R11: On page 1, 1vvv_vvvv loads vop_code, 0000_1ttt loads tc_code and 0000_01ss loads mult_code. On any other page these codes have no effect.
- R12: Instructions are carried out while power_down = 1.
- R13: bus_start at any point starts a new transaction that expects an address byte. Bytes that arrive after bus_stop and before the next bus_start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | Start or repeated-start condition seen |
| bus_stop | input | 1 | Stop condition seen |
| byte_valid | input | 1 | One received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| byte_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| ram_we | output | 1 | Display RAM write strobe |
| ram_bank | output | 3 | Bank of the RAM write |
| ram_col | output | 7 | Column of the RAM write |
| ram_wdata | output | 8 | Byte written to RAM |
| power_down | output | 1 | Power-down flag |
| page_sel | output | 2 | Instruction page |
| vop_code | output | 7 | Contrast voltage code |
| tc_code | output | 3 | Temperature coefficient code |
| mult_code | output | 2 | Voltage multiplier code |
| drive_off | output | 1 | Request to hold display drive at the off level |

## Verification
The hardest state to reach is the pointer at the last column of a given bank. Streaming data from reset to get there would take hundreds of bytes. Instead, the stimulus uses single-byte instruction frames (continuation flag 1) on page 0 to move the pointer to column 126 or 127 of bank 3, 4 or 5. It then switches to streaming data, so the row wrap, the full wrap to bank 0 and the icon-bank hold each show up within two or three writes. The ignored-read case is checked in the same way: a later valid frame writes data, and the bench confirms that the write lands at the pointer position from before the rejected frame.

// File: rtl/lcd_fe_pkg.sv
package lcd_fe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CTRL,
      ST_ONE,
      ST_STREAM,
      ST_SKIP
   } fe_state_e;

   localparam int CO_BIT = 7;
   localparam int RS_BIT = 6;
endpackage

// File: rtl/lcd_fe_seq.sv
module lcd_fe_seq
   import lcd_fe_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h3C
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       byte_valid,
   input  logic [7:0] byte_data,
   output logic       instr_stb,
   output logic       data_stb,
   output logic       byte_ack
);
   fe_state_e state_q, state_d;
   logic      rs_q, rs_d, take;

   always_comb begin
      state_d   = state_q;
      rs_d      = rs_q;
      take      = 1'b0;
      instr_stb = 1'b0;
      data_stb  = 1'b0;
      if (bus_start) begin
         state_d = ST_ADDR;
      end else if (bus_stop) begin
         state_d = ST_IDLE;
      end else if (byte_valid) begin
         unique case (state_q)
            ST_ADDR: begin
               if (byte_data[7:1] == SLAVE_ADDR && !byte_data[0]) begin
                  take    = 1'b1;
                  state_d = ST_CTRL;
               end else begin
                  state_d = ST_SKIP;
               end
            end
            ST_CTRL: begin
               take    = 1'b1;
               rs_d    = byte_data[RS_BIT];
               state_d = byte_data[CO_BIT] ? ST_ONE : ST_STREAM;
            end
            ST_ONE, ST_STREAM: begin
               take      = 1'b1;
               data_stb  = rs_q;
               instr_stb = !rs_q;
               if (state_q == ST_ONE) state_d = ST_CTRL;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         rs_q     <= 1'b0;
         byte_ack <= 1'b0;
      end else begin
         state_q  <= state_d;
         rs_q     <= rs_d;
         byte_ack <= take;
      end
   end
endmodule

// File: rtl/lcd_fe_cfg.sv
module lcd_fe_cfg #(
   parameter int BANKS = 6,
   parameter int XW    = 7,
   parameter int YW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          instr_stb,
   input  logic [7:0]    instr,
   output logic          power_down,
   output logic [1:0]    page_sel,
   output logic [6:0]    vop_code,
   output logic [2:0]    tc_code,
   output logic [1:0]    mult_code,
   output logic          set_x_stb,
   output logic          set_y_stb,
   output logic [XW-1:0] x_val,
   output logic [YW-1:0] y_val
);
   logic is_fset, page0, page1, y_ok;

   assign is_fset   = instr_stb && (instr[7:5] == 3'b001);
   assign page0     = (page_sel == 2'd0);
   assign page1     = (page_sel == 2'd1);
   assign y_ok      = 32'(instr[2:0]) < BANKS;
   assign set_x_stb = instr_stb && page0 && instr[7];
   assign set_y_stb = instr_stb && page0 && (instr[7:3] == 5'b01000) && y_ok;
   assign x_val     = instr[XW-1:0];
   assign y_val     = YW'(instr[2:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         power_down <= 1'b1;
         page_sel   <= 2'd0;
         vop_code   <= 7'h00;
         tc_code    <= 3'd0;
         mult_code  <= 2'd0;
      end else if (instr_stb) begin
         if (is_fset) begin
            power_down <= instr[2];
            page_sel   <= instr[1:0];
         end
         if (page1) begin
            if (instr[7])                  vop_code  <= instr[6:0];
            if (instr[7:3] == 5'b00001)    tc_code   <= instr[2:0];
            if (instr[7:2] == 6'b000001)   mult_code <= instr[1:0];
         end
      end
   end
endmodule

// File: rtl/lcd_fe_ptr.sv
module lcd_fe_ptr #(
   parameter int COLS  = 128,
   parameter int BANKS = 6,
   parameter int XW    = 7,
   parameter int YW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          data_stb,
   input  logic [7:0]    data_byte,
   input  logic          set_x_stb,
   input  logic [XW-1:0] x_val,
   input  logic          set_y_stb,
   input  logic [YW-1:0] y_val,
   output logic          ram_we,
   output logic [YW-1:0] ram_bank,
   output logic [XW-1:0] ram_col,
   output logic [7:0]    ram_wdata
);
   localparam logic [XW-1:0] LAST_X  = XW'(COLS - 1);
   localparam logic [YW-1:0] ICON_Y  = YW'(BANKS - 1);
   localparam logic [YW-1:0] LAST_DY = YW'(BANKS - 2);

   logic [XW-1:0] x_q, x_nxt;
   logic [YW-1:0] y_q, y_nxt;
   logic          at_last;

   assign at_last = (x_q == LAST_X);

   generate
      if (COLS == (1 << XW)) begin : g_pow2
         assign x_nxt = x_q + 1'b1;
      end else begin : g_npow2
         assign x_nxt = at_last ? '0 : x_q + 1'b1;
      end
   endgenerate

   always_comb begin
      if (y_q == ICON_Y)       y_nxt = y_q;
      else if (y_q == LAST_DY) y_nxt = '0;
      else                     y_nxt = y_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q       <= '0;
         y_q       <= '0;
         ram_we    <= 1'b0;
         ram_bank  <= '0;
         ram_col   <= '0;
         ram_wdata <= '0;
      end else begin
         ram_we <= data_stb;
         if (data_stb) begin
            ram_bank  <= y_q;
            ram_col   <= x_q;
            ram_wdata <= data_byte;
            x_q       <= x_nxt;
            if (at_last) y_q <= y_nxt;
         end else begin
            if (set_x_stb) x_q <= x_val;
            if (set_y_stb) y_q <= y_val;
         end
      end
   end
endmodule

// File: rtl/lcd_host_frontend.sv
module lcd_host_frontend #(
   parameter int         COLS       = 128,
   parameter int         BANKS      = 6,
   parameter logic [6:0] SLAVE_ADDR = 7'h3C,
   localparam int        XW         = $clog2(COLS),
   localparam int        YW         = $clog2(BANKS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          byte_valid,
   input  logic [7:0]    byte_data,
   output logic          byte_ack,
   output logic          ram_we,
   output logic [YW-1:0] ram_bank,
   output logic [XW-1:0] ram_col,
   output logic [7:0]    ram_wdata,
   output logic          power_down,
   output logic [1:0]    page_sel,
   output logic [6:0]    vop_code,
   output logic [2:0]    tc_code,
   output logic [1:0]    mult_code,
   output logic          drive_off
);
   initial begin : elab_chk
      if (COLS < 2 || COLS > 128) $error("COLS must lie in 2..128");
      if (BANKS < 3 || BANKS > 8) $error("BANKS must lie in 3..8");
   end

   logic          instr_stb, data_stb, set_x_stb, set_y_stb;
   logic [XW-1:0] x_val;
   logic [YW-1:0] y_val;

   lcd_fe_seq #(.SLAVE_ADDR(SLAVE_ADDR)) u_seq (
      .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .instr_stb(instr_stb), .data_stb(data_stb), .byte_ack(byte_ack)
   );

   lcd_fe_cfg #(.BANKS(BANKS), .XW(XW), .YW(YW)) u_cfg (
      .clk(clk), .rst(rst), .instr_stb(instr_stb), .instr(byte_data),
      .power_down(power_down), .page_sel(page_sel), .vop_code(vop_code),
      .tc_code(tc_code), .mult_code(mult_code),
      .set_x_stb(set_x_stb), .set_y_stb(set_y_stb), .x_val(x_val), .y_val(y_val)
   );

   lcd_fe_ptr #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_ptr (
      .clk(clk), .rst(rst), .data_stb(data_stb), .data_byte(byte_data),
      .set_x_stb(set_x_stb), .x_val(x_val), .set_y_stb(set_y_stb), .y_val(y_val),
      .ram_we(ram_we), .ram_bank(ram_bank), .ram_col(ram_col), .ram_wdata(ram_wdata)
   );

   assign drive_off = power_down;
endmodule

// File: rtl/lcd_fe_chk.sv
module lcd_fe_chk #(
   parameter int COLS  = 128,
   parameter int BANKS = 6,
   parameter int XW    = 7,
   parameter int YW    = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          byte_valid,
   input logic          byte_ack,
   input logic          ram_we,
   input logic [YW-1:0] ram_bank,
   input logic [XW-1:0] ram_col,
   input logic          power_down,
   input logic [1:0]    page_sel,
   input logic [6:0]    vop_code
);
   localparam logic [XW-1:0] LAST_X  = XW'(COLS - 1);
   localparam logic [YW-1:0] ICON_Y  = YW'(BANKS - 1);
   localparam logic [YW-1:0] LAST_DY = YW'(BANKS - 2);

   logic past_rst = 1'b0;
   always_ff @(posedge clk) past_rst <= rst;

   p_reset_state_r1: assert property (@(posedge clk)
      past_rst |-> (power_down && page_sel == 2'd0 && vop_code == 7'h00));

   p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
      byte_ack |-> $past(byte_valid));

   p_write_acked_r6: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> byte_ack);

   p_in_bounds_r7: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> (32'(ram_col) < COLS && 32'(ram_bank) < BANKS));

   p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
      (ram_we && $past(ram_we) && $past(ram_col) != LAST_X)
      |-> (ram_col == $past(ram_col) + 1'b1 && ram_bank == $past(ram_bank)));

   p_full_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (ram_we && $past(ram_we) && $past(ram_col) == LAST_X && $past(ram_bank) == LAST_DY)
      |-> (ram_col == '0 && ram_bank == '0));

   p_icon_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (ram_we && $past(ram_we) && $past(ram_bank) == ICON_Y) |-> (ram_bank == ICON_Y));

   p_cfg_needs_ack_r9: assert property (@(posedge clk) disable iff (rst)
      !($stable(power_down) && $stable(page_sel)) |-> byte_ack);
endmodule

bind lcd_host_frontend lcd_fe_chk #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW)) u_chk (
   .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_ack(byte_ack),
   .ram_we(ram_we), .ram_bank(ram_bank), .ram_col(ram_col),
   .power_down(power_down), .page_sel(page_sel), .vop_code(vop_code)
);

// File: tb/tb_lcd_host_frontend.sv
module tb_lcd_host_frontend;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       byte_ack, ram_we, power_down, drive_off;
   logic [2:0] ram_bank, tc_code;
   logic [6:0] ram_col, vop_code;
   logic [7:0] ram_wdata;
   logic [1:0] page_sel, mult_code;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   lcd_host_frontend dut (
      .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_valid(byte_valid), .byte_data(byte_data), .byte_ack(byte_ack),
      .ram_we(ram_we), .ram_bank(ram_bank), .ram_col(ram_col), .ram_wdata(ram_wdata),
      .power_down(power_down), .page_sel(page_sel), .vop_code(vop_code),
      .tc_code(tc_code), .mult_code(mult_code), .drive_off(drive_off)
   );

   // {byte, pd, page, vop, tc, mult}
   localparam logic [22:0] VEC [0:11] = '{
      {8'h20, 1'b0, 2'd0, 7'h00, 3'd0, 2'd0},
      {8'h21, 1'b0, 2'd1, 7'h00, 3'd0, 2'd0},
      {8'hD5, 1'b0, 2'd1, 7'h55, 3'd0, 2'd0},
      {8'h0E, 1'b0, 2'd1, 7'h55, 3'd6, 2'd0},
      {8'h06, 1'b0, 2'd1, 7'h55, 3'd6, 2'd2},
      {8'h8A, 1'b0, 2'd1, 7'h0A, 3'd6, 2'd2},
      {8'h25, 1'b1, 2'd1, 7'h0A, 3'd6, 2'd2},
      {8'h81, 1'b1, 2'd1, 7'h01, 3'd6, 2'd2},
      {8'h22, 1'b0, 2'd2, 7'h01, 3'd6, 2'd2},
      {8'hFF, 1'b0, 2'd2, 7'h01, 3'd6, 2'd2},
      {8'h0F, 1'b0, 2'd2, 7'h01, 3'd6, 2'd2},
      {8'h20, 1'b0, 2'd0, 7'h01, 3'd6, 2'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk) bus_start = 1'b1;
      @(negedge clk) bus_start = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk) bus_stop = 1'b1;
      @(negedge clk) bus_stop = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic wr(input string req, input logic [7:0] b, input int bank, input int col);
      send(b);
      chk({req, " we"}, ram_we, 1);
      chk({req, " bank"}, ram_bank, bank);
      chk({req, " col"}, ram_col, col);
      chk({req, " data"}, ram_wdata, b);
   endtask

   task automatic open_frame(input logic [7:0] ctrl);
      do_start();
      send(8'h78);
      send(ctrl);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 pd", power_down, 1);
      chk("R1 drive_off", drive_off, 1);
      chk("R1 page", page_sel, 0);
      chk("R1 vop", vop_code, 0);
      chk("R1 tc", tc_code, 0);
      chk("R1 mult", mult_code, 0);
      chk("R1 we", ram_we, 0);

      // R2, R3 address and control acknowledge; R9 R11 R12 vector walk
      do_start();
      send(8'h78);
      chk("R2 addr ack", byte_ack, 1);
      send(8'h00);
      chk("R3 ctrl ack", byte_ack, 1);
      for (int i = 0; i < 12; i++) begin
         send(VEC[i][22:15]);
         chk("R5 instr ack", byte_ack, 1);
         chk("R9 pd", power_down, VEC[i][14]);
         chk("R9 drive_off", drive_off, VEC[i][14]);
         chk("R9 page", page_sel, VEC[i][13:12]);
         chk("R11 R12 vop", vop_code, VEC[i][11:5]);
         chk("R11 tc", tc_code, VEC[i][4:2]);
         chk("R11 mult", mult_code, VEC[i][1:0]);
      end
      do_stop();

      // R4 single-byte instruction frames set Y=3, X=126; R5 stream data; R7 row wrap
      open_frame(8'h80);
      send(8'h43);
      send(8'h80);
      send(8'hFE);
      send(8'h40);
      wr("R6", 8'h11, 3, 126);
      wr("R6", 8'h22, 3, 127);
      wr("R7 row wrap", 8'h33, 4, 0);
      wr("R5 stream keeps data", 8'h80, 4, 1);
      do_stop();

      // R4 Co=1 data then a control byte
      open_frame(8'hC0);
      wr("R4 one data", 8'h5A, 4, 2);
      send(8'h80);
      chk("R4 next is control", ram_we, 0);
      send(8'hFF);
      send(8'h80);
      send(8'h44);
      send(8'h40);
      wr("R7 last addr", 8'hA1, 4, 127);
      wr("R7 full wrap", 8'hA2, 0, 0);
      do_stop();

      // R8 icon bank hold
      open_frame(8'h00);
      send(8'h45);
      send(8'hFF);
      do_stop();
      open_frame(8'h40);
      wr("R8 icon last", 8'hC1, 5, 127);
      wr("R8 icon hold", 8'hC2, 5, 0);
      do_stop();

      // R10 out-of-range bank ignored
      open_frame(8'h00);
      send(8'h46);
      do_stop();
      open_frame(8'h40);
      wr("R10 bad bank ignored", 8'hC3, 5, 1);
      do_stop();

      // R2 read and wrong address ignored
      do_start();
      send(8'h79);
      chk("R2 read no ack", byte_ack, 0);
      send(8'h00);
      send(8'h21);
      chk("R2 read no ack later", byte_ack, 0);
      chk("R2 read pd unchanged", power_down, 0);
      chk("R2 read page unchanged", page_sel, 0);
      do_stop();
      do_start();
      send(8'h7A);
      chk("R2 wrong addr no ack", byte_ack, 0);
      send(8'h40);
      send(8'h99);
      chk("R2 wrong addr no write", ram_we, 0);
      do_stop();

      // R13 bytes outside a transaction
      send(8'h55);
      chk("R13 idle no ack", byte_ack, 0);
      chk("R13 idle no write", ram_we, 0);
      open_frame(8'h40);
      wr("R2 pointer unchanged", 8'hC4, 5, 2);

      // R13 repeated start expects an address
      do_start();
      send(8'h78);
      chk("R13 restart addr ack", byte_ack, 1);
      chk("R13 restart no write", ram_we, 0);
      send(8'h40);
      wr("R13 after restart", 8'hC5, 5, 3);
      do_stop();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule